// File: doc/BRIEF.md
# Cache Line Alert Controller

This block gives every line of a small cache an extra watch bit, separate from the line's coherence state. The core marks lines it wants watched. When a watched line leaves the cache, the block records why and then diverts the core to a software handler, so that user code learns of the event as an asynchronous call. A line can leave because a remote core wrote it, or because of a local capacity or conflict replacement. The cache controller resolves addresses to line indices before it presents any command or eviction, so every command and event arrives here as a line index.

Software controls the block with commands on one bus:
- mark and unmark set and clear a single line's watch bit;
- unmark-all clears every watch bit;
- set-handler loads the handler address; clear-handler zeroes it and clears every watch bit;
- enable re-arms delivery.

On delivery the block saves the PC the core was about to run and masks further deliveries. Events that arrive while delivery is masked, or while an earlier alert is still waiting, are folded into one pending alert whose cause reads as lost. That alert is delivered as soon as software re-arms delivery. A defer input holds delivery off inside guarded regions. While the core runs in kernel mode, deliveries go to a fixed kernel vector instead of the user handler.

Top module: `alert_ctl_top`

## Requirements
- R1: Each line has its own watch bit, cleared at reset. Mark (op code 1) sets only the addressed line's bit. An eviction of a line whose bit is clear raises no alert, and any eviction clears that line's bit.
- R2: One cycle after a mark command, mark_resp_valid is 1. mark_resp_hit then shows whether the bit was already set before that command.
- R3: Unmark (op code 2) clears the addressed line's bit. Unmark-all (op code 3) clears every bit. A later eviction of a cleared line raises no alert.
- R4: Set-handler (op code 4) loads cmd_data as the handler address. Clear-handler (op code 5) zeroes the handler, clears every watch bit and drops any pending alert.
- R5: An eviction of a watched line, with a nonzero handler, makes alert_pending 1 in the next cycle.
- R6: alert_type encodes the cause: 1 is a remote write (evict_remote=1), 2 is a capacity or conflict eviction (evict_remote=0), 3 is lost. An event is recorded as lost when it arrives while an alert is already pending or while delivery is masked. Reset value is 0.
- R7: If an alert is pending, delivery is enabled and defer is 0, the next cycle shows a one-cycle redirect pulse. In that cycle redirect_pc holds the handler address, saved_pc holds the core_pc of the cycle before, and alert_enable is 0. Enable (op code 6) sets alert_enable again, and a pending alert is then delivered. alert_enable is 0 at reset.
- R8: A delivery made while kernel_mode is 1 sets redirect_kernel and puts the KERNEL_VEC parameter on redirect_pc.
- R9: While defer is 1 no redirect occurs, and the pending alert is kept until defer falls.
- R10: While the handler address is zero, evictions of watched lines raise no alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_line | input | LINE_W | Line index for mark and unmark |
| cmd_data | input | PC_W | Handler address for set-handler |
| mark_resp_valid | output | 1 | Mark response strobe |
| mark_resp_hit | output | 1 | Bit was already set before the mark |
| evict_valid | input | 1 | A line leaves the cache this cycle |
| evict_line | input | LINE_W | Index of the leaving line |
| evict_remote | input | 1 | 1 for a remote-write invalidation, 0 for a local replacement |
| core_pc | input | PC_W | PC the core would execute next |
| kernel_mode | input | 1 | Core runs in kernel mode |
| defer | input | 1 | Hold off delivery |
| redirect | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | PC_W | Redirect target |
| redirect_kernel | output | 1 | Redirect goes to the kernel vector |
| saved_pc | output | PC_W | PC saved at the last delivery |
| alert_type | output | 2 | Recorded cause |
| alert_enable | output | 1 | Delivery armed |
| alert_pending | output | 1 | Alert waiting for delivery |

## Verification
The assertions check the following on every cycle:
- a redirect always follows an armed pending alert and leaves delivery masked;
- defer forbids a redirect in the following cycle;
- a kernel redirect always carries the kernel vector;
- a pending alert seen while delivery is masked always reads as lost;
- a zero handler never lets an alert become pending;
- a mark response only follows a mark command.

The bench's scenarios are needed for the rest:
- the exact mark response value;
- the clearing effect of unmark, unmark-all and clear-handler on later evictions;
- the cause code of a first event compared with a merged one;
- the saved PC;
- that a deferred or masked alert is actually delivered once it is released.

// File: rtl/alert_ctl_pkg.sv
package alert_ctl_pkg;

    typedef enum logic [2:0] {
        OP_NOP           = 3'd0,
        OP_MARK          = 3'd1,
        OP_UNMARK        = 3'd2,
        OP_UNMARK_ALL    = 3'd3,
        OP_SET_HANDLER   = 3'd4,
        OP_CLEAR_HANDLER = 3'd5,
        OP_ENABLE        = 3'd6
    } alert_op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_REMOTE = 2'd1,
        CAUSE_EVICT  = 2'd2,
        CAUSE_LOST   = 2'd3
    } alert_cause_e;

    typedef struct packed {
        logic mark;
        logic unmark;
        logic flash;
        logic set_handler;
        logic clear_handler;
        logic enable;
    } cmd_decode_t;

    function automatic cmd_decode_t decode_cmd(logic valid, logic [2:0] op);
        cmd_decode_t d;
        d = '0;
        if (valid) begin
            d.mark          = (op == OP_MARK);
            d.unmark        = (op == OP_UNMARK);
            d.flash         = (op == OP_UNMARK_ALL) || (op == OP_CLEAR_HANDLER);
            d.set_handler   = (op == OP_SET_HANDLER);
            d.clear_handler = (op == OP_CLEAR_HANDLER);
            d.enable        = (op == OP_ENABLE);
        end
        return d;
    endfunction

    function automatic alert_cause_e merge_cause(logic already_waiting, logic masked,
                                                 logic remote);
        if (already_waiting || masked)
            return CAUSE_LOST;
        return remote ? CAUSE_REMOTE : CAUSE_EVICT;
    endfunction

endpackage

// File: rtl/alert_bit_array.sv
module alert_bit_array
    import alert_ctl_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int LINE_W = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_decode_t       cmd,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic              evict_valid,
    input  logic [LINE_W-1:0] evict_line,
    output logic              evict_marked,
    output logic              resp_valid,
    output logic              resp_hit
);

    logic [NUM_LINES-1:0] watch_q;

    // Eviction samples the bit before any update of this cycle.
    assign evict_marked = evict_valid && watch_q[evict_line];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic hit_evict, hit_cmd;
        assign hit_evict = evict_valid && (evict_line == LINE_W'(g));
        assign hit_cmd   = (cmd_line == LINE_W'(g));
        always_ff @(posedge clk) begin
            if (rst)
                watch_q[g] <= 1'b0;
            else if (hit_evict || cmd.flash)
                watch_q[g] <= 1'b0;
            else if (cmd.mark && hit_cmd)
                watch_q[g] <= 1'b1;
            else if (cmd.unmark && hit_cmd)
                watch_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
        end else begin
            resp_valid <= cmd.mark;
            resp_hit   <= cmd.mark && watch_q[cmd_line];
        end
    end

endmodule

// File: rtl/alert_cause_tracker.sv
module alert_cause_tracker
    import alert_ctl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         event_valid,
    input  logic         event_remote,
    input  logic         deliver,
    input  logic         enable_cmd,
    input  logic         clear_cmd,
    output logic         pending,
    output logic         enable,
    output alert_cause_e cause
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            enable  <= 1'b0;
            cause   <= CAUSE_NONE;
        end else begin
            if (clear_cmd) begin
                pending <= 1'b0;
            end else if (event_valid) begin
                pending <= 1'b1;
                cause   <= merge_cause(pending, !enable, event_remote);
            end else if (deliver) begin
                pending <= 1'b0;
            end

            if (deliver)
                enable <= 1'b0;
            else if (enable_cmd)
                enable <= 1'b1;
        end
    end

endmodule

// File: rtl/alert_delivery.sv
module alert_delivery
    import alert_ctl_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] KERNEL_VEC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_decode_t     cmd,
    input  logic [PC_W-1:0] cmd_data,
    input  logic            pending,
    input  logic            enable,
    input  logic            defer,
    input  logic            kernel_mode,
    input  logic [PC_W-1:0] core_pc,
    output logic            handler_live,
    output logic            deliver,
    output logic            redirect,
    output logic [PC_W-1:0] redirect_pc,
    output logic            redirect_kernel,
    output logic [PC_W-1:0] saved_pc
);

    logic [PC_W-1:0] handler_q;

    assign handler_live = (handler_q != '0);
    assign deliver      = pending && enable && !defer && handler_live;

    always_ff @(posedge clk) begin
        if (rst)
            handler_q <= '0;
        else if (cmd.clear_handler)
            handler_q <= '0;
        else if (cmd.set_handler)
            handler_q <= cmd_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect        <= 1'b0;
            redirect_kernel <= 1'b0;
            redirect_pc     <= '0;
            saved_pc        <= '0;
        end else begin
            redirect        <= deliver;
            redirect_kernel <= deliver && kernel_mode;
            if (deliver) begin
                redirect_pc <= kernel_mode ? KERNEL_VEC : handler_q;
                saved_pc    <= core_pc;
            end
        end
    end

endmodule

// File: rtl/alert_ctl_top.sv
module alert_ctl_top
    import alert_ctl_pkg::*;
#(
    parameter int              NUM_LINES  = 16,
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] KERNEL_VEC = 32'hFFFF_0100,
    localparam int             LINE_W     = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic [PC_W-1:0]   cmd_data,
    output logic              mark_resp_valid,
    output logic              mark_resp_hit,
    input  logic              evict_valid,
    input  logic [LINE_W-1:0] evict_line,
    input  logic              evict_remote,
    input  logic [PC_W-1:0]   core_pc,
    input  logic              kernel_mode,
    input  logic              defer,
    output logic              redirect,
    output logic [PC_W-1:0]   redirect_pc,
    output logic              redirect_kernel,
    output logic [PC_W-1:0]   saved_pc,
    output logic [1:0]        alert_type,
    output logic              alert_enable,
    output logic              alert_pending
);

    cmd_decode_t  cmd;
    logic         evict_marked;
    logic         handler_live;
    logic         deliver;
    alert_cause_e cause;

    assign cmd = decode_cmd(cmd_valid, cmd_op);

    alert_bit_array #(.NUM_LINES(NUM_LINES)) u_bits (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .cmd_line     (cmd_line),
        .evict_valid  (evict_valid),
        .evict_line   (evict_line),
        .evict_marked (evict_marked),
        .resp_valid   (mark_resp_valid),
        .resp_hit     (mark_resp_hit)
    );

    alert_cause_tracker u_track (
        .clk          (clk),
        .rst          (rst),
        .event_valid  (evict_marked && handler_live),
        .event_remote (evict_remote),
        .deliver      (deliver),
        .enable_cmd   (cmd.enable),
        .clear_cmd    (cmd.clear_handler),
        .pending      (alert_pending),
        .enable       (alert_enable),
        .cause        (cause)
    );

    alert_delivery #(.PC_W(PC_W), .KERNEL_VEC(KERNEL_VEC)) u_dlv (
        .clk             (clk),
        .rst             (rst),
        .cmd             (cmd),
        .cmd_data        (cmd_data),
        .pending         (alert_pending),
        .enable          (alert_enable),
        .defer           (defer),
        .kernel_mode     (kernel_mode),
        .core_pc         (core_pc),
        .handler_live    (handler_live),
        .deliver         (deliver),
        .redirect        (redirect),
        .redirect_pc     (redirect_pc),
        .redirect_kernel (redirect_kernel),
        .saved_pc        (saved_pc)
    );

    assign alert_type = cause;

endmodule

// File: rtl/alert_ctl_checker.sv
module alert_ctl_checker #(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] KERNEL_VEC = '0
) (
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic [2:0]      cmd_op,
    input logic            mark_resp_valid,
    input logic            defer,
    input logic            redirect,
    input logic [PC_W-1:0] redirect_pc,
    input logic            redirect_kernel,
    input logic [1:0]      alert_type,
    input logic            alert_enable,
    input logic            alert_pending,
    input logic            handler_live
);

    AST_MARK_RESP_AFTER_MARK: assert property (@(posedge clk) disable iff (rst)
        mark_resp_valid |-> $past(cmd_valid && cmd_op == 3'd1)); // R2

    AST_MASKED_PENDING_IS_LOST: assert property (@(posedge clk) disable iff (rst)
        (alert_pending && !alert_enable) |-> alert_type == 2'd3); // R6

    AST_REDIRECT_NEEDS_ARMED: assert property (@(posedge clk) disable iff (rst)
        redirect |-> $past(alert_pending && alert_enable)); // R7

    AST_REDIRECT_MASKS: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !alert_enable); // R7

    AST_KERNEL_VECTOR: assert property (@(posedge clk) disable iff (rst)
        redirect_kernel |-> (redirect && redirect_pc == KERNEL_VEC)); // R8

    AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        defer |=> !redirect); // R9

    AST_ZERO_HANDLER_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!handler_live && !alert_pending) |=> !alert_pending); // R10

endmodule

bind alert_ctl_top alert_ctl_checker #(.PC_W(PC_W), .KERNEL_VEC(KERNEL_VEC)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_valid       (cmd_valid),
    .cmd_op          (cmd_op),
    .mark_resp_valid (mark_resp_valid),
    .defer           (defer),
    .redirect        (redirect),
    .redirect_pc     (redirect_pc),
    .redirect_kernel (redirect_kernel),
    .alert_type      (alert_type),
    .alert_enable    (alert_enable),
    .alert_pending   (alert_pending),
    .handler_live    (handler_live)
);

// File: tb/tb_alert_ctl_top.sv
module tb_alert_ctl_top;

    localparam int              NUM_LINES = 16;
    localparam int              LINE_W    = $clog2(NUM_LINES);
    localparam int              PC_W      = 32;
    localparam logic [PC_W-1:0] KVEC      = 32'hFFFF_0100;
    localparam time             CLK_PERIOD = 10ns;

    localparam logic [2:0] C_NOP = 3'd0, C_MARK = 3'd1, C_UNMARK = 3'd2,
                           C_UNALL = 3'd3, C_SETH = 3'd4, C_CLRH = 3'd5, C_EN = 3'd6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [LINE_W-1:0] cmd_line = '0;
    logic [PC_W-1:0]   cmd_data = '0;
    logic              mark_resp_valid, mark_resp_hit;
    logic              evict_valid = 1'b0;
    logic [LINE_W-1:0] evict_line = '0;
    logic              evict_remote = 1'b0;
    logic [PC_W-1:0]   core_pc = '0;
    logic              kernel_mode = 1'b0;
    logic              defer = 1'b0;
    logic              redirect, redirect_kernel, alert_enable, alert_pending;
    logic [PC_W-1:0]   redirect_pc, saved_pc;
    logic [1:0]        alert_type;

    int vectors = 0;
    int fails   = 0;

    alert_ctl_top #(.NUM_LINES(NUM_LINES), .PC_W(PC_W), .KERNEL_VEC(KVEC)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_line(cmd_line), .cmd_data(cmd_data), .mark_resp_valid(mark_resp_valid),
        .mark_resp_hit(mark_resp_hit), .evict_valid(evict_valid), .evict_line(evict_line),
        .evict_remote(evict_remote), .core_pc(core_pc), .kernel_mode(kernel_mode),
        .defer(defer), .redirect(redirect), .redirect_pc(redirect_pc),
        .redirect_kernel(redirect_kernel), .saved_pc(saved_pc), .alert_type(alert_type),
        .alert_enable(alert_enable), .alert_pending(alert_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    bit              m_bits [NUM_LINES];
    logic [PC_W-1:0] m_handler, m_rpc, m_saved;
    bit              m_pending, m_enable, m_redir, m_rk, m_rv, m_rhit;
    logic [1:0]      m_type;

    function automatic void model_reset();
        for (int i = 0; i < NUM_LINES; i++) m_bits[i] = 0;
        m_handler = '0; m_rpc = '0; m_saved = '0;
        m_pending = 0; m_enable = 0; m_redir = 0; m_rk = 0; m_rv = 0; m_rhit = 0;
        m_type = 2'd0;
    endfunction

    function automatic void model_step();
        bit ev, dlv, old_bit;
        ev  = evict_valid && m_bits[evict_line] && (m_handler != '0);
        dlv = m_pending && m_enable && !defer && (m_handler != '0);
        old_bit = m_bits[cmd_line];
        m_redir = dlv;
        m_rk    = dlv && kernel_mode;
        if (dlv) begin
            m_rpc   = kernel_mode ? KVEC : m_handler;
            m_saved = core_pc;
        end
        if (cmd_valid && cmd_op == C_CLRH) m_pending = 0;
        else if (ev) begin
            m_type    = (m_pending || !m_enable) ? 2'd3 : (evict_remote ? 2'd1 : 2'd2);
            m_pending = 1;
        end else if (dlv) m_pending = 0;
        if (dlv) m_enable = 0;
        else if (cmd_valid && cmd_op == C_EN) m_enable = 1;
        m_rv   = cmd_valid && cmd_op == C_MARK;
        m_rhit = m_rv && old_bit;
        if (evict_valid) m_bits[evict_line] = 0;
        if (cmd_valid) begin
            case (cmd_op)
                C_MARK:   if (!(evict_valid && evict_line == cmd_line)) m_bits[cmd_line] = 1;
                C_UNMARK: if (!(evict_valid && evict_line == cmd_line)) m_bits[cmd_line] = 0;
                C_UNALL:  for (int i = 0; i < NUM_LINES; i++) m_bits[i] = 0;
                C_CLRH: begin
                    for (int i = 0; i < NUM_LINES; i++) m_bits[i] = 0;
                    m_handler = '0;
                end
                C_SETH:   m_handler = cmd_data;
                default: ;
            endcase
        end
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(redirect === m_redir, "R7 redirect", 64'(redirect), 64'(m_redir));
        chk(redirect_kernel === m_rk, "R8 redirect_kernel", 64'(redirect_kernel), 64'(m_rk));
        if (m_redir)
            chk(redirect_pc === m_rpc, "R7/R8 redirect_pc", 64'(redirect_pc), 64'(m_rpc));
        chk(saved_pc === m_saved, "R7 saved_pc", 64'(saved_pc), 64'(m_saved));
        chk(alert_enable === m_enable, "R7 alert_enable", 64'(alert_enable), 64'(m_enable));
        chk(alert_pending === m_pending, "R5 alert_pending", 64'(alert_pending), 64'(m_pending));
        chk(alert_type === m_type, "R6 alert_type", 64'(alert_type), 64'(m_type));
        chk(mark_resp_valid === m_rv, "R2 mark_resp_valid", 64'(mark_resp_valid), 64'(m_rv));
        if (m_rv)
            chk(mark_resp_hit === m_rhit, "R2 mark_resp_hit", 64'(mark_resp_hit), 64'(m_rhit));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        cmd_valid   = 1'b0;
        evict_valid = 1'b0;
        core_pc     = core_pc + 32'd4;
    endtask

    task automatic cmd(input logic [2:0] op, input int line, input logic [PC_W-1:0] data);
        cmd_valid = 1'b1; cmd_op = op; cmd_line = LINE_W'(line); cmd_data = data;
        tick();
    endtask

    task automatic evict(input int line, input bit remote);
        evict_valid = 1'b1; evict_line = LINE_W'(line); evict_remote = remote;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] pc_before;
        int seed_v;
        seed_v = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state: R6 type 0, R7 disabled
        chk(alert_type == 2'd0, "R6 reset type", 64'(alert_type), 0);
        chk(!alert_enable && !alert_pending && !redirect, "R7 reset state",
            64'({alert_enable, alert_pending, redirect}), 0);

        // R10: watched line evicted with zero handler raises nothing
        cmd(C_MARK, 1, '0);
        evict(1, 1'b1);
        chk(alert_pending == 1'b0, "R10 zero handler", 64'(alert_pending), 0);

        // R4 handler, R1 independent bits, R2 mark response
        cmd(C_SETH, 0, 32'h0000_4000);
        cmd(C_EN, 0, '0);
        cmd(C_MARK, 3, '0);
        chk(mark_resp_hit == 1'b0, "R2 first mark", 64'(mark_resp_hit), 0);
        cmd(C_MARK, 3, '0);
        chk(mark_resp_hit == 1'b1, "R2 second mark", 64'(mark_resp_hit), 1);
        evict(5, 1'b1);
        chk(alert_pending == 1'b0, "R1 unwatched eviction", 64'(alert_pending), 0);
        defer = 1'b1;
        evict(3, 1'b1);
        chk(alert_pending && alert_type == 2'd1, "R5 remote cause",
            64'({alert_pending, alert_type}), 64'({1'b1, 2'd1}));
        // R9: deferred for several cycles
        repeat (4) tick();
        chk(alert_pending && !redirect, "R9 defer holds", 64'({alert_pending, redirect}), 64'(2'b10));
        defer = 1'b0;
        pc_before = core_pc;
        tick();
        chk(redirect && redirect_pc == 32'h0000_4000, "R7 redirect to handler",
            64'(redirect_pc), 64'h4000);
        chk(saved_pc == pc_before, "R7 saved pc", 64'(saved_pc), 64'(pc_before));
        chk(!alert_enable, "R7 masked after delivery", 64'(alert_enable), 0);

        // R6 lost while masked, R7 re-enable delivers
        cmd(C_MARK, 4, '0);
        evict(4, 1'b0);
        chk(alert_type == 2'd3, "R6 lost while masked", 64'(alert_type), 3);
        tick();
        chk(!redirect, "R7 no delivery while masked", 64'(redirect), 0);
        cmd(C_EN, 0, '0);
        tick();
        chk(redirect, "R7 delivery after re-enable", 64'(redirect), 1);
        cmd(C_EN, 0, '0);

        // R6 capacity cause on first event
        cmd(C_MARK, 6, '0);
        defer = 1'b1;
        evict(6, 1'b0);
        chk(alert_type == 2'd2, "R6 capacity cause", 64'(alert_type), 2);
        // R8 kernel vector
        kernel_mode = 1'b1;
        defer = 1'b0;
        tick();
        chk(redirect_kernel && redirect_pc == KVEC, "R8 kernel vector",
            64'(redirect_pc), 64'(KVEC));
        kernel_mode = 1'b0;
        cmd(C_EN, 0, '0);

        // R3 unmark and unmark-all
        cmd(C_MARK, 7, '0);
        cmd(C_UNMARK, 7, '0);
        evict(7, 1'b1);
        chk(!alert_pending, "R3 unmark", 64'(alert_pending), 0);
        cmd(C_MARK, 8, '0);
        cmd(C_MARK, 9, '0);
        cmd(C_UNALL, 0, '0);
        evict(9, 1'b1);
        chk(!alert_pending, "R3 unmark all", 64'(alert_pending), 0);

        // R4 clear-handler flashes bits
        cmd(C_MARK, 2, '0);
        cmd(C_CLRH, 0, '0);
        cmd(C_MARK, 2, '0);
        chk(mark_resp_hit == 1'b0, "R4 clear flashes bits", 64'(mark_resp_hit), 0);

        // Constrained random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            defer       = ($urandom_range(0, 9) == 0);
            kernel_mode = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 2) == 0) begin
                evict_valid  = 1'b1;
                evict_line   = LINE_W'($urandom_range(0, NUM_LINES - 1));
                evict_remote = 1'($urandom_range(0, 1));
            end
            if (r < 30) begin
                cmd_valid = 1'b1; cmd_op = C_MARK;
            end else if (r < 38) begin
                cmd_valid = 1'b1; cmd_op = C_UNMARK;
            end else if (r < 40) begin
                cmd_valid = 1'b1; cmd_op = C_UNALL;
            end else if (r < 43) begin
                cmd_valid = 1'b1; cmd_op = C_SETH;
            end else if (r < 45) begin
                cmd_valid = 1'b1; cmd_op = C_CLRH;
            end else if (r < 60) begin
                cmd_valid = 1'b1; cmd_op = C_EN;
            end
            cmd_line = LINE_W'($urandom_range(0, NUM_LINES - 1));
            cmd_data = ($urandom_range(0, 7) == 0) ? '0 : $urandom();
            tick();
        end
        defer = 1'b0;
        kernel_mode = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule